// File: doc/BRIEF.md
# Polarization Pair Sum/Difference Processor

This block sits in the digital signal chain of a polarization-sensitive imager. Each incoming row holds pixels whose polarization analyzers alternate: horizontally neighbouring samples see orthogonal linear polarizations. The block joins every two neighbours into one output pixel. For each pair it produces a weighted sum, which is the intensity, and a weighted difference, which is the polarization contrast. The output therefore has half the horizontal resolution of the input.

The input must already have had its dark-row column reference subtracted, so samples arrive as signed values. Four signed fixed-point weights set the combination. Together they fold in two things: the correction for leakage between the two polarization components in a non-ideal analyzer, and any enhancement scaling.

The common normalising divisor is left out. A single array-wide scale factor is absorbed by a later range stretch. At the reset weights of 1.0, the block computes the plain sum and the plain difference. Weights are written through a small write port and are meant to change only between frames.

Top module: `pol_pair_proc`

## Requirements
- R1: After a start-of-row pixel (`in_sol`=1), the accepted pixels of the row are paired in order. The first pixel of each pair is the first component (P1) and the next accepted pixel is the second component (P2). Each completed pair yields exactly one result.
- R2: A pixel accepted with `in_sol`=1 always starts a new pair as P1. A P1 still waiting for its partner is dropped without producing a result, so an odd-length row cannot shift the pairing of the next row.
- R3: With weights in signed two's complement holding `COEF_FRAC` fractional bits, the block computes two raw values: the sum value is w0·P1 + w1·P2 and the difference value is w2·P1 − w3·P2. Both are at full precision. Each is rounded to an integer by adding one half and flooring, so halves round toward plus infinity.
- R4: `out_sum` is unsigned. A rounded sum below 0 gives 0, and a rounded sum above 2^OUT_W−1 gives 2^OUT_W−1.
- R5: `out_diff` is signed two's complement and is clamped to the range −2^(OUT_W−1) to 2^(OUT_W−1)−1.
- R6: Reset loads all four weights with 1.0 (value 2^COEF_FRAC), so that `out_sum` = P1+P2 and `out_diff` = P1−P2.
- R7: A write with `cfg_we`=1 loads `cfg_data` into the weight selected by `cfg_sel`: 0 selects w0, 1 selects w1, 2 selects w2 and 3 selects w3. The new weight applies to every pair completed after the write.
- R8: `out_valid` pulses for one cycle per completed pair. It rises after the third rising edge, counting the edge that accepts P2. `out_valid` is never high in any other cycle.
- R9: While `rst_n` is low, and after it is released, `out_valid` stays low until a new pair completes. The first pixel accepted after reset is P1.
- R10: Cycles with `in_valid`=0 are ignored. Such idle gaps between P1 and P2 do not disturb the pairing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Weight write strobe |
| cfg_sel | input | 2 | Weight select (0..3 = w0..w3) |
| cfg_data | input | COEF_W | Signed fixed-point weight value |
| in_valid | input | 1 | Input pixel valid |
| in_sol | input | 1 | Pixel is the first of a row |
| in_pix | input | PIX_W | Signed reference-corrected pixel |
| out_valid | output | 1 | Pair result valid |
| out_sum | output | OUT_W | Unsigned weighted sum |
| out_diff | output | OUT_W | Signed weighted difference |

## Verification
The bench drives odd-length rows followed by a new start-of-row. A design that kept its pairing phase across rows would pair the leftover pixel with the next row's first pixel and shift every later result. Weights are chosen so the products land exactly on halves, both positive and negative. Truncation, or rounding half away from zero, then shows up as an error of one.

Large weights push the sum past both of its clamp limits and the difference past both of its signed limits. A design that wraps instead of saturating returns values of the wrong sign. Idle gaps, back-to-back pairs and a reset in the middle of a pair expose a design whose latency varies, or one that pairs the first pixel after reset with stale data.

// File: rtl/pol_pkg.sv
// Shared defaults and weight selector encoding for the polarization pair processor.
// Assumes all users take widths from these defaults unless overridden at the top.
package pol_pkg;
    localparam int PIX_W_DEF     = 12;
    localparam int COEF_W_DEF    = 16;
    localparam int COEF_FRAC_DEF = 8;
    localparam int OUT_W_DEF     = 16;
    localparam int NUM_COEF      = 4;

    typedef enum logic [1:0] {
        W_SUM_P1  = 2'd0,
        W_SUM_P2  = 2'd1,
        W_DIFF_P1 = 2'd2,
        W_DIFF_P2 = 2'd3
    } wsel_e;
endpackage

// File: rtl/pol_coef_regs.sv
// Weight register bank: four signed fixed-point weights, written one at a time.
// Assumes writes occur between frames; reset value of every weight is 1.0.
module pol_coef_regs
    import pol_pkg::*;
#(
    parameter int COEF_W    = COEF_W_DEF,
    parameter int COEF_FRAC = COEF_FRAC_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [1:0]                 cfg_sel,
    input  logic [COEF_W-1:0]          cfg_data,
    output logic [NUM_COEF*COEF_W-1:0] coef_flat
);
    localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << COEF_FRAC;

    for (genvar g = 0; g < NUM_COEF; g++) begin : g_wreg
        logic [COEF_W-1:0] w_q;
        // Load this weight when selected, unity on reset (R6, R7).
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                w_q <= UNITY;
            end else if (cfg_we && (cfg_sel == 2'(g))) begin
                w_q <= cfg_data;
            end
        end
        assign coef_flat[g*COEF_W +: COEF_W] = w_q;
    end
endmodule

// File: rtl/pol_pair_gather.sv
// Pair former: holds the first component of each pair and emits both
// components together when the partner arrives. Start-of-row restarts pairing.
// Assumes in_pix is only meaningful when in_valid is high.
module pol_pair_gather
    import pol_pkg::*;
#(
    parameter int PIX_W = PIX_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sol,
    input  logic [PIX_W-1:0] in_pix,
    output logic             pair_valid,
    output logic [PIX_W-1:0] pair_p1,
    output logic [PIX_W-1:0] pair_p2
);
    logic             have_p1;
    logic [PIX_W-1:0] held_p1;

    // Track pairing phase and emit a completed pair for one cycle (R1, R2, R10).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_p1    <= 1'b0;
            held_p1    <= '0;
            pair_valid <= 1'b0;
            pair_p1    <= '0;
            pair_p2    <= '0;
        end else begin
            pair_valid <= 1'b0;
            if (in_valid) begin
                if (in_sol || !have_p1) begin
                    held_p1 <= in_pix;
                    have_p1 <= 1'b1;
                end else begin
                    pair_valid <= 1'b1;
                    pair_p1    <= held_p1;
                    pair_p2    <= in_pix;
                    have_p1    <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/pol_lane.sv
// One arithmetic lane: two signed products, add or subtract, round half up,
// clamp to an unsigned or signed output range. Two register stages.
// Assumes COEF_FRAC >= 1 and the rounded width exceeds OUT_W.
module pol_lane
    import pol_pkg::*;
#(
    parameter int PIX_W        = PIX_W_DEF,
    parameter int COEF_W       = COEF_W_DEF,
    parameter int COEF_FRAC    = COEF_FRAC_DEF,
    parameter int OUT_W        = OUT_W_DEF,
    parameter bit SUBTRACT     = 1'b0,
    parameter bit UNSIGNED_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pair_valid,
    input  logic [PIX_W-1:0]  p1,
    input  logic [PIX_W-1:0]  p2,
    input  logic [COEF_W-1:0] k1,
    input  logic [COEF_W-1:0] k2,
    output logic              res_valid,
    output logic [OUT_W-1:0]  res
);
    localparam int PROD_W = PIX_W + COEF_W;
    localparam int ACC_W  = PROD_W + 2;
    localparam int RND_W  = ACC_W - COEF_FRAC;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (COEF_FRAC - 1);
    localparam logic signed [RND_W-1:0] UMAX = RND_W'({OUT_W{1'b1}});
    localparam logic signed [RND_W-1:0] SMAX = RND_W'({(OUT_W-1){1'b1}});
    localparam logic signed [RND_W-1:0] SMIN = ~SMAX;

    logic signed [PROD_W-1:0] prod1_q, prod2_q;
    logic                     prod_v_q;
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  acc_r;
    logic signed [RND_W-1:0]  rnd;
    logic [OUT_W-1:0]         clamped;

    // Stage 1: register both full-precision products (R3).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod1_q  <= '0;
            prod2_q  <= '0;
            prod_v_q <= 1'b0;
        end else begin
            prod_v_q <= pair_valid;
            prod1_q  <= $signed(p1) * $signed(k1);
            prod2_q  <= $signed(p2) * $signed(k2);
        end
    end

    // Combine products with the lane's sign selection.
    if (SUBTRACT) begin : g_sub
        assign acc = ACC_W'(prod1_q) - ACC_W'(prod2_q);
    end else begin : g_add
        assign acc = ACC_W'(prod1_q) + ACC_W'(prod2_q);
    end

    // Round half toward plus infinity by adding one half and flooring (R3).
    always_comb begin
        acc_r = acc + HALF;
        rnd   = acc_r[ACC_W-1:COEF_FRAC];
    end

    // Clamp to the lane's output range (R4, R5).
    if (UNSIGNED_OUT) begin : g_uclamp
        always_comb begin
            if (rnd < 0)         clamped = '0;
            else if (rnd > UMAX) clamped = '1;
            else                 clamped = rnd[OUT_W-1:0];
        end
    end else begin : g_sclamp
        always_comb begin
            if (rnd < SMIN)      clamped = SMIN[OUT_W-1:0];
            else if (rnd > SMAX) clamped = SMAX[OUT_W-1:0];
            else                 clamped = rnd[OUT_W-1:0];
        end
    end

    // Stage 2: register the final result and its valid (R8).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res       <= '0;
        end else begin
            res_valid <= prod_v_q;
            res       <= clamped;
        end
    end
endmodule

// File: rtl/pol_pair_proc.sv
// Top: pairs orthogonal-polarization neighbours and produces a weighted sum
// (unsigned intensity) and weighted difference (signed contrast) per pair.
// Assumes reference-corrected signed pixels; weights change only between frames.
module pol_pair_proc
    import pol_pkg::*;
#(
    parameter int PIX_W     = PIX_W_DEF,
    parameter int COEF_W    = COEF_W_DEF,
    parameter int COEF_FRAC = COEF_FRAC_DEF,
    parameter int OUT_W     = OUT_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_sel,
    input  logic [COEF_W-1:0]       cfg_data,
    input  logic                    in_valid,
    input  logic                    in_sol,
    input  logic [PIX_W-1:0]        in_pix,
    output logic                    out_valid,
    output logic [OUT_W-1:0]        out_sum,
    output logic signed [OUT_W-1:0] out_diff
);
    localparam int NUM_LANES = 2;

    logic [NUM_COEF*COEF_W-1:0] coef_flat;
    logic                       pair_valid;
    logic [PIX_W-1:0]           pair_p1, pair_p2;
    logic [NUM_LANES-1:0]       lane_valid;
    logic [OUT_W-1:0]           lane_res [NUM_LANES];

    pol_coef_regs #(.COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)) u_coef (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_data  (cfg_data),
        .coef_flat (coef_flat)
    );

    pol_pair_gather #(.PIX_W(PIX_W)) u_gather (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sol     (in_sol),
        .in_pix     (in_pix),
        .pair_valid (pair_valid),
        .pair_p1    (pair_p1),
        .pair_p2    (pair_p2)
    );

    // Lane 0: weighted sum, unsigned clamp. Lane 1: weighted difference, signed clamp.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        pol_lane #(
            .PIX_W        (PIX_W),
            .COEF_W       (COEF_W),
            .COEF_FRAC    (COEF_FRAC),
            .OUT_W        (OUT_W),
            .SUBTRACT     (g == 1),
            .UNSIGNED_OUT (g == 0)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .pair_valid (pair_valid),
            .p1         (pair_p1),
            .p2         (pair_p2),
            .k1         (coef_flat[(2*g)*COEF_W +: COEF_W]),
            .k2         (coef_flat[(2*g+1)*COEF_W +: COEF_W]),
            .res_valid  (lane_valid[g]),
            .res        (lane_res[g])
        );
    end

    assign out_valid = &lane_valid;
    assign out_sum   = lane_res[0];
    assign out_diff  = $signed(lane_res[1]);
endmodule

// File: rtl/pol_pair_proc_chk.sv
// Timing checker for the pair processor, attached by bind.
// Assumes the fixed three-edge latency from acceptance of the second pixel.
module pol_pair_proc_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_sol,
    input logic out_valid
);
    // R9: reset forces the output idle on the next cycle.
    assert_reset_idle_R9: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R8: a result only follows an accepted pixel three edges earlier (R2: never a start-of-row one).
    assert_valid_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid, 3) && !$past(in_sol, 3)));

    // R1: one result per pair, so results are never in consecutive cycles.
    assert_no_back_to_back_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R2: a start-of-row pixel opens a pair and never completes one.
    assert_sol_opens_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sol) |-> ##3 !out_valid);
endmodule

bind pol_pair_proc pol_pair_proc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sol    (in_sol),
    .out_valid (out_valid)
);

// File: tb/pol_pair_proc_tb.sv
// Bench: behavioural reference model compared on every clock.
module pol_pair_proc_tb;
    localparam int PIX_W = 12;
    localparam int COEF_W = 16;
    localparam int FRAC = 8;
    localparam int OUT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [COEF_W-1:0] cfg_data = '0;
    logic in_valid = 1'b0;
    logic in_sol = 1'b0;
    logic [PIX_W-1:0] in_pix = '0;
    logic out_valid;
    logic [OUT_W-1:0] out_sum;
    logic signed [OUT_W-1:0] out_diff;

    int checks = 0;
    int errors = 0;
    string cur_req = "R6";

    always #10 clk = ~clk;

    pol_pair_proc #(.PIX_W(PIX_W), .COEF_W(COEF_W), .COEF_FRAC(FRAC), .OUT_W(OUT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .in_valid(in_valid), .in_sol(in_sol), .in_pix(in_pix),
        .out_valid(out_valid), .out_sum(out_sum), .out_diff(out_diff)
    );

    // Reference model state
    longint w [4];
    bit     ph;
    longint held;
    bit     m1v, m2v, m3v;
    longint m1s, m1d, m2s, m2d, m3s, m3d;

    function automatic longint rnd_half_up(longint v);
        return (v + (longint'(1) <<< (FRAC - 1))) >>> FRAC;
    endfunction

    function automatic longint clamp(longint v, longint lo, longint hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    // Model: pairing, weights and three-stage latency
    always @(posedge clk) begin
        longint px;
        if (!rst_n) begin
            ph = 0; m1v = 0; m2v = 0; m3v = 0;
            for (int i = 0; i < 4; i++) w[i] = longint'(1) <<< FRAC;
        end else begin
            m3v = m2v; m3s = m2s; m3d = m2d;
            m2v = m1v; m2s = m1s; m2d = m1d;
            m1v = 0;
            if (cfg_we) w[cfg_sel] = longint'($signed(cfg_data));
            if (in_valid) begin
                px = longint'($signed(in_pix));
                if (in_sol || !ph) begin
                    held = px; ph = 1;
                end else begin
                    m1v = 1;
                    m1s = clamp(rnd_half_up(w[0]*held + w[1]*px), 0, (longint'(1) <<< OUT_W) - 1);
                    m1d = clamp(rnd_half_up(w[2]*held - w[3]*px),
                                -(longint'(1) <<< (OUT_W-1)), (longint'(1) <<< (OUT_W-1)) - 1);
                    ph = 0;
                end
            end
        end
    end

    // Compare outputs away from the active edge
    always @(negedge clk) begin
        if (rst_n && (m3v || out_valid)) begin
            checks++;
            if (out_valid !== m3v) begin
                errors++;
                $display("FAIL %s out_valid actual=%0b expected=%0b", cur_req, out_valid, m3v);
            end else begin
                checks++;
                if (longint'(out_sum) != m3s || longint'(out_diff) != m3d) begin
                    errors++;
                    $display("FAIL %s result actual=%0d/%0d expected=%0d/%0d",
                             cur_req, out_sum, out_diff, m3s, m3d);
                end
            end
        end
    end

    task automatic push(input bit sol, input int v);
        @(negedge clk);
        in_valid = 1'b1; in_sol = sol; in_pix = PIX_W'(v);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sol = 1'b0;
        end
    endtask

    task automatic wr(input int sel, input int val);
        @(negedge clk);
        in_valid = 1'b0; in_sol = 1'b0;
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_data = COEF_W'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lfsr;
        // R9: output idle during reset
        repeat (4) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R9 out_valid in reset actual=%0b expected=0", out_valid);
        end
        @(negedge clk); rst_n = 1'b1;
        idle(3);

        // R6: reset weights give plain sum and difference; R1 pairing; R8 back-to-back
        cur_req = "R6";
        push(1, 100); push(0, 40); push(0, 7); push(0, -20);
        idle(5);

        // R10: idle gaps between components
        cur_req = "R10";
        push(1, 300); idle(2); push(0, 55); idle(1); push(0, -9); idle(3); push(0, 12);
        idle(5);

        // R2: odd row then new start-of-row discards the dangling component
        cur_req = "R2";
        push(1, 5); push(0, 6); push(0, 9); push(1, 1); push(0, 2);
        push(1, 77); push(1, 11); push(0, 33);
        idle(5);

        // R7, R3: weight writes and rounding of exact halves
        cur_req = "R7";
        wr(0, 512); wr(1, 128); wr(2, 320); wr(3, 192);
        idle(2);
        cur_req = "R3";
        push(1, 3); push(0, 1);     // sum 6.5 -> 7, diff 3.0
        push(0, -3); push(0, 1);    // sum -5.5 -> clamp 0, diff -4.5 -> -4
        push(0, 1); push(0, 1);     // sum 2.5 -> 3, diff 0.5 -> 1
        idle(5);

        // R4, R5: saturation at both ends
        cur_req = "R4";
        wr(0, 32767); wr(1, 32767); wr(2, 32767); wr(3, 32767);
        idle(2);
        push(1, 2047); push(0, 2047);     // sum high clamp, diff 0
        push(0, -2048); push(0, -2048);   // sum low clamp
        cur_req = "R5";
        push(0, 2047); push(0, -2048);    // diff high clamp
        push(0, -2048); push(0, 2047);    // diff low clamp
        idle(5);

        // R3: mixed-sign weights over a pseudo-random stream
        cur_req = "R3";
        wr(0, -200); wr(1, 77); wr(2, 413); wr(3, -129);
        idle(2);
        lfsr = 32'h1ace;
        for (int i = 0; i < 120; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
            if ((lfsr & 7) == 0) idle(1);
            push(((lfsr >> 5) & 15) == 0, (lfsr & 4095) - 2048);
        end
        idle(5);

        // R9: reset mid-pair; first pixel afterwards is a new P1 (R6 weights restored)
        cur_req = "R9";
        push(1, 400);
        @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        push(0, 50); push(0, 20); push(0, 8); push(0, 3);
        idle(6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule